// File: doc/BRIEF.md
# Hashed Page Table Search Engine

This block turns a virtual page number into a physical page number by walking a hashed translation table held in memory. On an accepted request it captures the page number and the table base. It folds the page number into a slot index and reads that slot's eight entries one at a time, comparing each tag against the request. If the whole slot fails, it moves to a second slot picked by an alternate hash and walks it the same way. The first valid entry whose tag equals the request ends the walk with a hit and its physical page number. If all sixteen entries fail, the walk ends with a miss, and software must then consult the complete backup table.

The memory side is a single-read port. A one-cycle request strobe carries a byte address, and the response arrives with a valid strobe after any number of cycles. The engine never has more than one read open. The slot count is a power of two, and each slot spans eight entries times the entry size in bytes.

Top module: `hpt_search_engine`

## Requirements
- R1: After reset, `req_ready` is 1 and `done` and `mem_req` are 0.
- R2: The primary slot index is the XOR of the upper half `req_vpn[19:10]` and the lower half `req_vpn[9:0]`, keeping the low 6 bits. The first read goes to `tbl_base + index*64`.
- R3: Reads within a slot go to entries 0 through 7 in ascending order, 8 bytes apart. At most one read is open at a time, and the next `mem_req` follows the response cycle by exactly one cycle.
- R4: An entry word has the valid flag at bit 36, the tag at bits [35:16] and the physical page number at bits [15:0]. An entry with the valid flag clear never matches, even when its tag is equal.
- R5: The walk stops at the first matching entry, including entry 7 of the primary slot. `done` rises one cycle after that response with `done_hit`=1 and that entry's page number, and no further read is issued.
- R6: If all 8 primary entries fail, entries 0 through 7 of the secondary slot are read. The secondary slot index is the bitwise inverse of the primary index over 6 bits.
- R7: If both slots fail, `done` rises after exactly 16 reads with `done_hit`=0 and `done_ppn`=0.
- R8: `done` is a one-cycle pulse. `done_hit` and `done_ppn` keep their values until the next `done`.
- R9: The page number and table base are captured when a request is accepted. Later changes on `req_vpn` and `tbl_base` do not affect the walk in progress.
- R10: `req_ready` is 1 in the cycle `done` is 1, so a request held pending is accepted then, and its first `mem_req` appears in the following cycle.
- R11: A `mem_rvalid` pulse while no read is open has no effect: it produces no `done`, no read, and no change to the next walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request strobe |
| req_vpn | input | 20 | Virtual page number to resolve |
| tbl_base | input | 32 | Byte address of slot 0 of the table |
| req_ready | output | 1 | Engine idle and able to accept a request |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 37 | Entry word returned by memory |
| done | output | 1 | One-cycle completion pulse |
| done_hit | output | 1 | 1 when the last walk found a match |
| done_ppn | output | 16 | Physical page number of the last hit, 0 on miss |

## Verification
Two events can fall in the same cycle. A match on the final primary entry coincides with the point where the engine would switch to the alternate slot. Completion also coincides with the acceptance of a waiting request. The first case is provoked by planting matches at primary entry 7 and at secondary entry 0. It is judged by the read count stopping at eight and the page number coming from the primary slot. The second case is provoked by holding `req_valid` high, with new pins, across an entire walk. It is judged by checking that the first result still uses the captured values and that the next read strobe, carrying the new slot address, appears in the cycle after `done`.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_state_e;

endpackage

// File: rtl/hpt_hash_unit.sv
module hpt_hash_unit #(
  parameter int VPN_W = 20,
  parameter int IDX_W = 6
) (
  input  logic [VPN_W-1:0] vpn_i,
  output logic [IDX_W-1:0] prim_idx_o,
  output logic [IDX_W-1:0] alt_idx_o
);
  localparam int LO_W = VPN_W / 2;
  localparam int HI_W = VPN_W - LO_W;

  // fold the two halves of the page number together, keep the index bits
  function automatic logic [IDX_W-1:0] fold_index(input logic [VPN_W-1:0] v);
    logic [HI_W-1:0] folded;
    folded = v[VPN_W-1:LO_W] ^ HI_W'(v[LO_W-1:0]);
    return IDX_W'(folded);
  endfunction

  // secondary slot: bitwise inverse of the primary index
  function automatic logic [IDX_W-1:0] alt_index(input logic [IDX_W-1:0] p);
    return ~p;
  endfunction

  always_comb begin
    prim_idx_o = fold_index(vpn_i);
    alt_idx_o  = alt_index(prim_idx_o);
  end

endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 6,
  parameter int ENTRIES   = 8,
  parameter int PTE_BYTES = 8,
  parameter int ENT_W     = 3
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  slot_i,
  input  logic [ENT_W-1:0]  entry_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int SLOT_BYTES = ENTRIES * PTE_BYTES;

  function automatic logic [ADDR_W-1:0] entry_addr(
    input logic [ADDR_W-1:0] b,
    input logic [IDX_W-1:0]  s,
    input logic [ENT_W-1:0]  e
  );
    return b + (ADDR_W'(s) * ADDR_W'(SLOT_BYTES)) + (ADDR_W'(e) * ADDR_W'(PTE_BYTES));
  endfunction

  assign addr_o = entry_addr(base_i, slot_i, entry_i);

endmodule

// File: rtl/hpt_pte_match.sv
module hpt_pte_match #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 16,
  parameter int PTE_W = 1 + VPN_W + PPN_W
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] ppn_o
);
  logic             ent_valid;
  logic [VPN_W-1:0] ent_tag;

  always_comb begin
    ent_valid = pte_i[PTE_W-1];
    ent_tag   = pte_i[PTE_W-2:PPN_W];
    ppn_o     = pte_i[PPN_W-1:0];
    hit_o     = ent_valid && (ent_tag == vpn_i);
  end

endmodule

// File: rtl/hpt_walk_ctrl.sv
module hpt_walk_ctrl
  import hpt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ENT_W   = 3,
  parameter int PPN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire_i,
  input  logic             rsp_valid_i,
  input  logic             entry_hit_i,
  input  logic [PPN_W-1:0] entry_ppn_i,
  output logic             idle_o,
  output logic             issue_o,
  output logic             use_alt_o,
  output logic [ENT_W-1:0] entry_o,
  output logic             done_o,
  output logic             done_hit_o,
  output logic [PPN_W-1:0] done_ppn_o
);
  localparam logic [ENT_W-1:0] LAST_ENT = ENT_W'(ENTRIES - 1);

  walk_state_e      state_q;
  logic [ENT_W-1:0] entry_q;
  logic             alt_q;
  logic             done_q;
  logic             hit_q;
  logic [PPN_W-1:0] ppn_q;

  // named events for the walk
  logic ev_rsp;
  logic ev_match;
  logic ev_slot_spent;
  logic ev_rehash;
  logic ev_giveup;
  logic ev_step;

  always_comb begin
    ev_rsp        = (state_q == ST_WAIT) && rsp_valid_i;
    ev_match      = ev_rsp && entry_hit_i;
    ev_slot_spent = ev_rsp && !entry_hit_i && (entry_q == LAST_ENT);
    ev_rehash     = ev_slot_spent && !alt_q;
    ev_giveup     = ev_slot_spent && alt_q;
    ev_step       = ev_rsp && !entry_hit_i && (entry_q != LAST_ENT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      entry_q <= '0;
      alt_q   <= 1'b0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      ppn_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_fire_i) begin
            state_q <= ST_ISSUE;
            entry_q <= '0;
            alt_q   <= 1'b0;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (ev_match) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            hit_q   <= 1'b1;
            ppn_q   <= entry_ppn_i;
          end else if (ev_rehash) begin
            state_q <= ST_ISSUE;
            alt_q   <= 1'b1;
            entry_q <= '0;
          end else if (ev_giveup) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            hit_q   <= 1'b0;
            ppn_q   <= '0;
          end else if (ev_step) begin
            state_q <= ST_ISSUE;
            entry_q <= entry_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o     = (state_q == ST_IDLE);
  assign issue_o    = (state_q == ST_ISSUE);
  assign use_alt_o  = alt_q;
  assign entry_o    = entry_q;
  assign done_o     = done_q;
  assign done_hit_o = hit_q;
  assign done_ppn_o = ppn_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_ALT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(use_alt_o) |-> ($past(entry_o) == LAST_ENT) && (entry_o == '0)); // R6

  AST_MISS_AFTER_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !done_hit_o) |-> $past(use_alt_o) && ($past(entry_o) == LAST_ENT)); // R7

endmodule

// File: rtl/hpt_search_engine.sv
module hpt_search_engine #(
  parameter int VPN_W      = 20,
  parameter int PPN_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int SLOT_IDX_W = 6,
  parameter int ENTRIES    = 8,
  parameter int PTE_BYTES  = 8,
  localparam int PTE_W     = 1 + VPN_W + PPN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [ADDR_W-1:0] tbl_base,
  output logic              req_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [PTE_W-1:0]  mem_rdata,
  output logic              done,
  output logic              done_hit,
  output logic [PPN_W-1:0]  done_ppn
);
  localparam int ENT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0]      vpn_q;
  logic [ADDR_W-1:0]     base_q;
  logic                  req_fire;
  logic [SLOT_IDX_W-1:0] prim_idx;
  logic [SLOT_IDX_W-1:0] alt_idx;
  logic [SLOT_IDX_W-1:0] slot_idx;
  logic                  use_alt;
  logic [ENT_W-1:0]      entry_idx;
  logic                  entry_hit;
  logic [PPN_W-1:0]      entry_ppn;
  logic                  idle;
  logic                  issue;

  assign req_ready = idle;
  assign req_fire  = req_valid && idle;

  // capture page number and base at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      base_q <= '0;
    end else if (req_fire) begin
      vpn_q  <= req_vpn;
      base_q <= tbl_base;
    end
  end

  hpt_hash_unit #(
    .VPN_W (VPN_W),
    .IDX_W (SLOT_IDX_W)
  ) u_hash (
    .vpn_i      (vpn_q),
    .prim_idx_o (prim_idx),
    .alt_idx_o  (alt_idx)
  );

  assign slot_idx = use_alt ? alt_idx : prim_idx;

  hpt_addr_gen #(
    .ADDR_W    (ADDR_W),
    .IDX_W     (SLOT_IDX_W),
    .ENTRIES   (ENTRIES),
    .PTE_BYTES (PTE_BYTES),
    .ENT_W     (ENT_W)
  ) u_addr (
    .base_i  (base_q),
    .slot_i  (slot_idx),
    .entry_i (entry_idx),
    .addr_o  (mem_addr)
  );

  hpt_pte_match #(
    .VPN_W (VPN_W),
    .PPN_W (PPN_W),
    .PTE_W (PTE_W)
  ) u_match (
    .pte_i (mem_rdata),
    .vpn_i (vpn_q),
    .hit_o (entry_hit),
    .ppn_o (entry_ppn)
  );

  hpt_walk_ctrl #(
    .ENTRIES (ENTRIES),
    .ENT_W   (ENT_W),
    .PPN_W   (PPN_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_fire_i  (req_fire),
    .rsp_valid_i (mem_rvalid),
    .entry_hit_i (entry_hit),
    .entry_ppn_i (entry_ppn),
    .idle_o      (idle),
    .issue_o     (issue),
    .use_alt_o   (use_alt),
    .entry_o     (entry_idx),
    .done_o      (done),
    .done_hit_o  (done_hit),
    .done_ppn_o  (done_ppn)
  );

  assign mem_req = issue;

  // open-read tracker seen only from the port side
  logic rd_open_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_open_q <= 1'b0;
    else if (mem_req)    rd_open_q <= 1'b1;
    else if (mem_rvalid) rd_open_q <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rd_open_q); // R3

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_hit) |-> $past(mem_rvalid) && $past(mem_rdata[PTE_W-1])
                           && ($past(mem_rdata[PTE_W-2:PPN_W]) == vpn_q)); // R4

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(done_ppn) && $stable(done_hit)); // R8

  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready); // R10

  AST_NO_READ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req); // R11

endmodule

// File: tb/test_hpt_search_engine.sv
module test_hpt_search_engine;
  localparam int VPN_W = 20;
  localparam int PPN_W = 16;
  localparam int ADDR_W = 32;
  localparam int PTE_W = 37;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [VPN_W-1:0]  req_vpn;
  logic [ADDR_W-1:0] tbl_base;
  logic              req_ready;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rvalid;
  logic [PTE_W-1:0]  mem_rdata;
  logic              done;
  logic              done_hit;
  logic [PPN_W-1:0]  done_ppn;

  always #5 clk = ~clk;

  hpt_search_engine i_hpt_search_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
    .tbl_base(tbl_base), .req_ready(req_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .done_hit(done_hit), .done_ppn(done_ppn)
  );

  // memory image, read log, latency
  logic [PTE_W-1:0]  mem_img [logic [31:0]];
  logic [ADDR_W-1:0] log_addr [0:63];
  int                log_n;
  int                lat;
  int                stray_req;
  int                stray_done;
  logic [PTE_W-1:0]  stray_pte;
  logic [ADDR_W-1:0] cur_a;
  int                n_cmp;
  int                n_bad;

  function automatic logic [PTE_W-1:0] mk_pte(input bit v, input logic [19:0] tag,
                                              input logic [15:0] ppn);
    return {v, tag, ppn};
  endfunction

  function automatic int prim_slot(input logic [19:0] v);
    int hi, lo;
    hi = int'(v) / 1024;
    lo = int'(v) % 1024;
    return (hi ^ lo) % 64;
  endfunction

  function automatic int alt_slot(input logic [19:0] v);
    return 63 - prim_slot(v);
  endfunction

  function automatic logic [31:0] ent_addr(input logic [31:0] b, input int slot, input int e);
    return b + 32'(slot * 64) + 32'(e * 8);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    stray_done = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (stray_req != stray_done) begin
        stray_done = stray_req;
        mem_rvalid = 1'b1;
        mem_rdata  = stray_pte;
      end else if (mem_req) begin
        cur_a = mem_addr;
        if (log_n < 64) log_addr[log_n] = cur_a;
        log_n++;
        repeat (lat) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = mem_img.exists(cur_a) ? mem_img[cur_a] : '0;
      end
    end
  end

  task automatic wait_done(input string req, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
    if (!seen) chk(req, "done never rose", 0, 1);
  endtask

  task automatic start_req(input logic [19:0] v, input logic [31:0] b);
    @(negedge clk);
    req_valid = 1'b1;
    req_vpn   = v;
    tbl_base  = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_trace(input string req, input logic [19:0] v, input logic [31:0] b,
                             input int n);
    for (int i = 0; i < n && i < 64; i++) begin
      int slot;
      slot = (i < 8) ? prim_slot(v) : alt_slot(v);
      chk(req, $sformatf("read %0d address", i), log_addr[i], ent_addr(b, slot, i % 8));
    end
  endtask

  task automatic run_search(input string req, input logic [19:0] v, input logic [31:0] b,
                            input int l, input bit exp_hit, input logic [15:0] exp_ppn,
                            input int exp_reads);
    bit seen;
    lat   = l;
    log_n = 0;
    start_req(v, b);
    wait_done(req, seen);
    chk(req, "hit flag", done_hit, exp_hit);
    chk(req, "ppn", done_ppn, exp_ppn);
    chk(req, "read count", log_n, exp_reads);
    check_trace(req, v, b, exp_reads);
    @(negedge clk);
    chk("R8", "done lasts one cycle", done, 0);
  endtask

  task automatic t_reset();
    chk("R1", "req_ready after reset", req_ready, 1);
    chk("R1", "done after reset", done, 0);
    chk("R1", "mem_req after reset", mem_req, 0);
  endtask

  task automatic t_first_entry();
    logic [19:0] v = 20'hABCDE;
    logic [31:0] b = 32'h0010_0000;
    mem_img.delete();
    mem_img[ent_addr(b, prim_slot(v), 0)] = mk_pte(1, v, 16'h1234);
    run_search("R2", v, b, 1, 1, 16'h1234, 1);
    repeat (5) @(negedge clk);
    chk("R8", "ppn held after done", done_ppn, 16'h1234);
    chk("R8", "hit held after done", done_hit, 1);
  endtask

  task automatic t_ordered_walk();
    logic [19:0] v = 20'h12345;
    logic [31:0] b = 32'h0004_0000;
    int s;
    s = prim_slot(v);
    mem_img.delete();
    mem_img[ent_addr(b, s, 2)] = mk_pte(0, v, 16'hDEAD);        // invalid, equal tag: R4
    mem_img[ent_addr(b, s, 4)] = mk_pte(1, v ^ 20'h1, 16'h2222);
    mem_img[ent_addr(b, s, 5)] = mk_pte(1, v, 16'h0BEE);
    mem_img[ent_addr(b, s, 6)] = mk_pte(1, v, 16'h1111);        // later match ignored: R5
    run_search("R4", v, b, 3, 1, 16'h0BEE, 6);
    chk("R3", "ordered walk read count", log_n, 6);
  endtask

  task automatic t_last_primary();
    logic [19:0] v = 20'h0F00F;
    logic [31:0] b = 32'h0800_0000;
    mem_img.delete();
    mem_img[ent_addr(b, prim_slot(v), 7)] = mk_pte(1, v, 16'hA7A7);
    mem_img[ent_addr(b, alt_slot(v), 0)]  = mk_pte(1, v, 16'hB0B0);
    run_search("R5", v, b, 2, 1, 16'hA7A7, 8);
  endtask

  task automatic t_secondary();
    logic [19:0] v = 20'h55AA5;
    logic [31:0] b = 32'h0001_0000;
    mem_img.delete();
    for (int e = 0; e < 8; e++)
      mem_img[ent_addr(b, prim_slot(v), e)] = mk_pte(1, v ^ 20'h80, 16'h0F0F);
    mem_img[ent_addr(b, alt_slot(v), 3)] = mk_pte(1, v, 16'h7777);
    run_search("R6", v, b, 1, 1, 16'h7777, 12);
  endtask

  task automatic t_miss();
    logic [19:0] v = 20'hFFFFF;
    logic [31:0] b = 32'h0200_0000;
    mem_img.delete();
    mem_img[ent_addr(b, alt_slot(v), 7)] = mk_pte(0, v, 16'h3333);
    run_search("R7", v, b, 1, 0, 16'h0000, 16);
  endtask

  task automatic t_back_to_back();
    logic [19:0] va = 20'h00F0F;
    logic [31:0] ba = 32'h2000_0000;
    logic [19:0] vb = 20'h3C3C3;
    logic [31:0] bb = 32'h3000_0000;
    bit seen;
    mem_img.delete();
    mem_img[ent_addr(ba, prim_slot(va), 1)] = mk_pte(1, va, 16'h0A0A);
    mem_img[ent_addr(bb, prim_slot(vb), 0)] = mk_pte(1, vb, 16'h0B0B);
    lat   = 2;
    log_n = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vpn   = va;
    tbl_base  = ba;
    @(negedge clk);
    req_vpn  = vb;  // pins change while walk A runs: R9
    tbl_base = bb;
    wait_done("R9", seen);
    chk("R9", "first walk ppn", done_ppn, 16'h0A0A);
    chk("R9", "first walk reads", log_n, 2);
    check_trace("R9", va, ba, 2);
    chk("R10", "ready during done", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "read strobe after done", mem_req, 1);
    chk("R10", "second walk first address", mem_addr, ent_addr(bb, prim_slot(vb), 0));
    wait_done("R10", seen);
    chk("R10", "second walk ppn", done_ppn, 16'h0B0B);
    chk("R10", "second walk hit", done_hit, 1);
  endtask

  task automatic t_stray();
    logic [19:0] v = 20'h13579;
    logic [31:0] b = 32'h0000_4000;
    mem_img.delete();
    log_n     = 0;
    stray_pte = mk_pte(1, v, 16'h5555);
    stray_req = stray_req + 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R11", "no done after stray response", done, 0);
    end
    chk("R11", "no read after stray response", log_n, 0);
    mem_img[ent_addr(b, prim_slot(v), 2)] = mk_pte(1, v, 16'h4444);
    run_search("R11", v, b, 2, 1, 16'h4444, 3);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0; log_n = 0; lat = 1; stray_req = 0; stray_pte = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_vpn = '0; tbl_base = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_entry();
    t_ordered_walk();
    t_last_primary();
    t_secondary();
    t_miss();
    t_back_to_back();
    t_stray();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule